// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache Lookup

This block is the read-lookup path of a two-way set-associative data cache. Its set and word selection use only bits that lie inside the 4 KB page offset, and those bits are the same in the virtual and the physical address. The cache can therefore latch its index from the virtual address while a separate translation buffer converts the virtual page number into a physical page number. One cycle after a request, the stored physical tags of the selected set are compared against the page number that the translation buffer returns. The result is a hit flag and one 32-bit word of the 32-byte line.

The geometry is 32-byte lines, 128 sets and two ways. That gives 8 KB, which is the page size multiplied by the associativity. If the translation buffer reports a miss, the lookup is held and a stall is raised until a valid page number arrives. Lines are loaded whole through a fill port, which is driven by whatever models the next memory level. Each set has one replacement bit.

Top module: `vipt_dcache`

## Requirements
- R1: Reset clears every valid bit, so any lookup after reset reports a miss until a line is filled.
- R2: The set is taken from virtual address bits [11:5] and the word from bits [4:2]. Bits [31:12] of the virtual address have no effect on the result.
- R3: A lookup hits only when a valid way of the selected set holds a physical tag equal to `tlb_ppn`. A different page number misses.
- R4: When the translation is already valid, `rsp_valid` rises in the cycle after the one in which `req_valid` is sampled, and never in the request cycle itself.
- R5: While a pending lookup sees `tlb_hit` low, `xlat_stall` is high and `rsp_valid` is low. The lookup is held, and requests presented during the stall are not accepted. When `tlb_hit` rises, the held lookup responds.
- R6: A fill writes the tag, sets valid and loads all eight words. Word i of the line is `fill_line[32*i+31 : 32*i]`, and a lookup with address bits [4:2] = i returns it.
- R7: Both ways of a set can hold different tags at the same time, and each can hit independently.
- R8: A fill uses the way that already holds the same tag if there is one. Otherwise it uses the first invalid way, way 0 before way 1. Otherwise it uses the least recently used way. Hits and fills both make their way the most recently used.
- R9: When a response is a miss, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the lookup |
| tlb_hit | input | 1 | Translation valid for the pending lookup |
| tlb_ppn | input | 20 | Physical page number from the translation buffer |
| fill_valid | input | 1 | Line fill strobe |
| fill_set | input | 7 | Set receiving the fill |
| fill_tag | input | 20 | Physical tag of the filled line |
| fill_line | input | 256 | Eight 32-bit words, word 0 in the low bits |
| rsp_valid | output | 1 | Lookup result is present this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Selected word on a hit, zero on a miss |
| xlat_stall | output | 1 | Pending lookup is waiting for translation |

## Verification
Lookups run against a set that holds two lines with different tags. Some lookups keep the same page offset but change the virtual page number, which shows that only offset bits steer the index. Others change the physical page number presented at compare time, which separates hits from tag misses, and a neighbouring set shows that the index is actually decoded. A fixed sequence of hits and fills then shows which way each new tag evicts, including a refill of a tag that is already present. A held translation with an extra request pushed during the stall tells a correctly held lookup apart from one that was overwritten or answered twice.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_PAGE_OFS_W = 12;
  localparam int DEF_LINE_OFS_W = 5;
  localparam int DEF_WORD_W     = 32;
  localparam int NUM_WAYS       = 2;

  typedef enum logic {WAY_A = 1'b0, WAY_B = 1'b1} way_t;

  // Fill placement: reuse a matching tag, then the first free way, then the
  // way the replacement bit names.
  function automatic way_t pick_fill_way(input logic [1:0] valid,
                                         input logic [1:0] match,
                                         input way_t       lru_way);
    if (match[0])       return WAY_A;
    else if (match[1])  return WAY_B;
    else if (!valid[0]) return WAY_A;
    else if (!valid[1]) return WAY_B;
    else                return lru_way;
  endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [SET_W-1:0] fl_set,
  output logic             fl_valid,
  output logic [TAG_W-1:0] fl_tag,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[fl_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[fl_set] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign fl_valid = valid_q[fl_set];
  assign fl_tag   = tag_q[fl_set];

  // R6
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(fl_set)]);

  // R6
  fill_sets_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tag_q[$past(fl_set)] == $past(wr_tag));

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [LINE_W-1:0] wr_line
);

  logic [WORD_W-1:0] mem_q [SETS*WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_q[{wr_set, WSEL_W'(i)}] <= wr_line[i*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_data = mem_q[{rd_set, rd_word}];

endmodule

// File: rtl/vipt_lru.sv
module vipt_lru
  import vipt_cache_pkg::*;
#(
  parameter int SETS = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  way_t             touch_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  way_t             fill_way,
  output way_t             victim_way
);

  // One bit per set, naming the way to evict next.
  logic [SETS-1:0] lru_q;
  logic            touch_live;

  assign touch_live = touch_en && !(fill_en && fill_set == touch_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      if (touch_live) lru_q[touch_set] <= ~touch_way;
      if (fill_en)    lru_q[fill_set]  <= ~fill_way;
    end
  end

  assign victim_way = way_t'(lru_q[fill_set]);

  // R8
  touch_moves_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_live |=> lru_q[$past(touch_set)] != $past(touch_way));

  // R8
  fill_moves_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lru_q[$past(fill_set)] != $past(fill_way));

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_cache_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int PAGE_OFS_W = DEF_PAGE_OFS_W,
  parameter int LINE_OFS_W = DEF_LINE_OFS_W,
  parameter int WORD_W     = DEF_WORD_W,
  localparam int BYTE_SEL_W = $clog2(WORD_W / 8),
  localparam int SET_W      = PAGE_OFS_W - LINE_OFS_W,
  localparam int SETS       = 1 << SET_W,
  localparam int WSEL_W     = LINE_OFS_W - BYTE_SEL_W,
  localparam int WORDS      = 1 << WSEL_W,
  localparam int LINE_W     = WORDS * WORD_W,
  localparam int PPN_W      = ADDR_W - PAGE_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [PPN_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data,
  output logic              xlat_stall
);

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] va);
    return va[LINE_OFS_W +: SET_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] va);
    return va[BYTE_SEL_W +: WSEL_W];
  endfunction

  logic unused_vaddr_bits;
  assign unused_vaddr_bits = ^{req_vaddr[ADDR_W-1:PAGE_OFS_W], req_vaddr[BYTE_SEL_W-1:0]};

  // Lookup stage: index latched from page-offset bits, no translation needed.
  logic              s1_valid;
  logic [SET_W-1:0]  s1_set;
  logic [WSEL_W-1:0] s1_word;
  logic              hold_stage;

  assign hold_stage = s1_valid && !tlb_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_set   <= '0;
      s1_word  <= '0;
    end else if (!hold_stage) begin
      s1_valid <= req_valid;
      s1_set   <= set_of(req_vaddr);
      s1_word  <= word_of(req_vaddr);
    end
  end

  // Way arrays
  logic [NUM_WAYS-1:0] rd_valid;
  logic [PPN_W-1:0]    rd_tag   [NUM_WAYS];
  logic [WORD_W-1:0]   rd_word  [NUM_WAYS];
  logic [NUM_WAYS-1:0] fl_valid;
  logic [PPN_W-1:0]    fl_tag   [NUM_WAYS];
  logic [NUM_WAYS-1:0] fl_match;
  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] fill_way_oh;
  way_t                fill_way;
  way_t                victim_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    vipt_tag_store #(.SETS(SETS), .TAG_W(PPN_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (s1_set),
      .rd_valid (rd_valid[w]),
      .rd_tag   (rd_tag[w]),
      .fl_set   (fill_set),
      .fl_valid (fl_valid[w]),
      .fl_tag   (fl_tag[w]),
      .wr_en    (fill_way_oh[w]),
      .wr_tag   (fill_tag)
    );

    vipt_data_store #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
      .clk     (clk),
      .rd_set  (s1_set),
      .rd_word (s1_word),
      .rd_data (rd_word[w]),
      .wr_en   (fill_way_oh[w]),
      .wr_set  (fill_set),
      .wr_line (fill_line)
    );

    assign way_hit[w]     = rd_valid[w] && (rd_tag[w] == tlb_ppn);
    assign fl_match[w]    = fl_valid[w] && (fl_tag[w] == fill_tag);
    assign fill_way_oh[w] = fill_valid && (int'(fill_way) == w);
  end

  assign fill_way = pick_fill_way(fl_valid, fl_match, victim_way);

  // Result: physical tag compare against the returned page number.
  logic              lookup_done;
  logic              any_hit;
  logic [WORD_W-1:0] hit_word;
  way_t              hit_way;

  always_comb begin
    hit_word = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_word = hit_word | (rd_word[w] & {WORD_W{way_hit[w]}});
    end
  end

  assign lookup_done = s1_valid && tlb_hit;
  assign any_hit     = |way_hit;
  assign hit_way     = way_t'(way_hit[1]);

  assign rsp_valid  = lookup_done;
  assign rsp_hit    = lookup_done && any_hit;
  assign rsp_data   = rsp_hit ? hit_word : '0;
  assign xlat_stall = hold_stage;

  vipt_lru #(.SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (rsp_hit),
    .touch_set  (s1_set),
    .touch_way  (hit_way),
    .fill_en    (fill_valid),
    .fill_set   (fill_set),
    .fill_way   (fill_way),
    .victim_way (victim_way)
  );

  // R5
  stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_stall |-> !rsp_valid);

  // R5
  stall_holds_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_stall |=> (s1_set == $past(s1_set)) && (s1_word == $past(s1_word)) && s1_valid);

  // R4
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid) || $past(xlat_stall)));

  // R9
  miss_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

  // R7
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R8
  single_fill_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_way_oh));

endmodule

// File: tb/vipt_dcache_bench.sv
module vipt_dcache_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         tlb_hit;
  logic [19:0]  tlb_ppn;
  logic         fill_valid;
  logic [6:0]   fill_set;
  logic [19:0]  fill_tag;
  logic [255:0] fill_line;
  logic         rsp_valid;
  logic         rsp_hit;
  logic [31:0]  rsp_data;
  logic         xlat_stall;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  vipt_dcache u_vipt_dcache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .fill_valid(fill_valid),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .xlat_stall(xlat_stall)
  );

  localparam logic [19:0] TAG_A = 20'h0A11A;
  localparam logic [19:0] TAG_B = 20'h0B22B;
  localparam logic [19:0] TAG_C = 20'h0C33C;
  localparam logic [19:0] TAG_D = 20'h0D44D;

  // Expected word content: tag, set, word index and a salt packed together.
  function automatic logic [31:0] word_val(input logic [19:0] tag, input logic [6:0] set,
                                           input logic [2:0] idx, input logic [1:0] salt);
    return {tag[11:0], set, idx, salt, 8'h5A};
  endfunction

  function automatic logic [31:0] va(input logic [19:0] vpn, input logic [6:0] set,
                                     input logic [2:0] idx);
    return {vpn, set, idx, 2'b00};
  endfunction

  // Vector table: virtual address, page number at compare, expected hit, fill salt.
  localparam int NV = 6;
  localparam logic [31:0] TV_VA [NV] = '{
    {20'h12345, 7'd5, 3'd3, 2'b00},
    {20'hABCDE, 7'd5, 3'd3, 2'b00},
    {20'h00001, 7'd5, 3'd7, 2'b00},
    {20'h12345, 7'd5, 3'd1, 2'b00},
    {20'h12345, 7'd6, 3'd3, 2'b00},
    {20'h77777, 7'd5, 3'd0, 2'b00}
  };
  localparam logic [19:0] TV_PPN [NV] = '{TAG_A, TAG_A, TAG_B, TAG_C, TAG_A, TAG_A};
  localparam bit          TV_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string       TV_REQ [NV] = '{"R2/R3/R6", "R2", "R7", "R3", "R2", "R6"};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [6:0] set, input logic [19:0] tag, input logic [1:0] salt);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_set   = set;
    fill_tag   = tag;
    for (int i = 0; i < 8; i++) fill_line[i*32 +: 32] = word_val(tag, set, 3'(i), salt);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] addr, input logic [19:0] ppn, input bit exp_hit,
                        input logic [1:0] salt, input string req);
    logic [31:0] exp_data;
    exp_data = exp_hit ? word_val(ppn, addr[11:5], addr[4:2], salt) : 32'h0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = addr;
    tlb_hit   = 1'b1;
    tlb_ppn   = ppn;
    #1;
    // R4: nothing in the request cycle
    check(rsp_valid == 1'b0, "R4 early", {31'b0, rsp_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " valid"}, {31'b0, rsp_valid}, 32'h1);
    check(rsp_hit == exp_hit, {req, " hit"}, {31'b0, rsp_hit}, {31'b0, exp_hit});
    check(rsp_data == exp_data, {req, " data"}, rsp_data, exp_data);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; tlb_hit = 1'b0; tlb_ppn = '0;
    fill_valid = 1'b0; fill_set = '0; fill_tag = '0; fill_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check(xlat_stall == 1'b0, "R1 reset stall", {31'b0, xlat_stall}, 32'h0);
    lookup(va(20'h1, 7'd5, 3'd3), TAG_A, 1'b0, 2'd0, "R1/R9 empty");

    fill(7'd5, TAG_A, 2'd0);
    fill(7'd5, TAG_B, 2'd0);
    for (int v = 0; v < NV; v++) lookup(TV_VA[v], TV_PPN[v], TV_HIT[v], 2'd0, TV_REQ[v]);

    // R8 replacement order: A was touched last, so a new tag evicts B.
    lookup(va(20'h2, 7'd5, 3'd2), TAG_A, 1'b1, 2'd0, "R8 touch A");
    fill(7'd5, TAG_C, 2'd0);
    lookup(va(20'h2, 7'd5, 3'd2), TAG_B, 1'b0, 2'd0, "R8 B evicted");
    lookup(va(20'h2, 7'd5, 3'd4), TAG_A, 1'b1, 2'd0, "R8 A kept");
    lookup(va(20'h2, 7'd5, 3'd5), TAG_C, 1'b1, 2'd0, "R8 C placed");
    fill(7'd5, TAG_D, 2'd0);
    lookup(va(20'h3, 7'd5, 3'd6), TAG_A, 1'b0, 2'd0, "R8 A evicted");
    lookup(va(20'h3, 7'd5, 3'd6), TAG_D, 1'b1, 2'd0, "R8 D placed");
    // R8 refill of a present tag reuses its way
    fill(7'd5, TAG_C, 2'd2);
    lookup(va(20'h3, 7'd5, 3'd1), TAG_C, 1'b1, 2'd2, "R8 C refilled");
    lookup(va(20'h3, 7'd5, 3'd1), TAG_D, 1'b1, 2'd0, "R8 D survives refill");

    // R5 translation stall with a competing request
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va(20'h9, 7'd5, 3'd7); tlb_hit = 1'b0; tlb_ppn = TAG_D;
    @(negedge clk);
    req_vaddr = va(20'h9, 7'd6, 3'd0);
    check(xlat_stall == 1'b1, "R5 stall", {31'b0, xlat_stall}, 32'h1);
    check(rsp_valid == 1'b0, "R5 no rsp", {31'b0, rsp_valid}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(xlat_stall == 1'b1, "R5 stall held", {31'b0, xlat_stall}, 32'h1);
    tlb_hit = 1'b1;
    #1;
    check(rsp_valid == 1'b1, "R5 release valid", {31'b0, rsp_valid}, 32'h1);
    check(rsp_hit == 1'b1, "R5 release hit", {31'b0, rsp_hit}, 32'h1);
    check(rsp_data == word_val(TAG_D, 7'd5, 3'd7, 2'd0), "R5 release data",
          rsp_data, word_val(TAG_D, 7'd5, 3'd7, 2'd0));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R5 stalled request dropped", {31'b0, rsp_valid}, 32'h0);
    check(xlat_stall == 1'b0, "R5 stall clear", {31'b0, xlat_stall}, 32'h0);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(va(20'h3, 7'd5, 3'd6), TAG_D, 1'b0, 2'd0, "R1 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule